// File: doc/BRIEF.md
# Per-Pin Edge Flag Interrupt Controller

This block watches an eight-bit input port and records signal edges on each pin in a sticky per-pin flag. Each pin has two independent enables, one for rising transitions and one for falling transitions. An enabled transition sets that pin's flag, and the flag stays set until software clears it. The interrupt request is the OR of all flags, gated by a global enable, and it comes from a register.

Software reaches the block through a small register port. Reads are combinational and have no side effects. Reading the synchronized port value never touches the flags, so an edge that arrives while the port is being read is still recorded. Flags are cleared with a write-zero-to-clear mask. When a new edge and a clear hit the same bit in the same cycle, the new edge wins.

Top module: `pin_edge_irq`

## Requirements
- R1: While `rstN` is low at a clock edge, all rising enables, falling enables, flags, the global enable and `irq` become 0.
- R2: Offset 0 reads the port value after a two-flop synchronizer. A pin change driven before clock edge k is visible at offset 0 after edge k+1. Writes to offset 0 change nothing.
- R3: A 0-to-1 transition of a synchronized pin whose bit is set in the rising enable register (offset 1) sets that pin's bit in the flag register (offset 3). The flag bit is visible after edge k+2 for a pin change before edge k.
- R4: A 1-to-0 transition of a synchronized pin whose bit is set in the falling enable register (offset 2) sets that pin's flag bit, with the same timing as R3.
- R5: A transition whose direction is not enabled for that pin leaves the pin's flag bit unchanged.
- R6: A set flag bit stays set until a write to offset 3 clears it.
- R7: A write to offset 3 updates the flags to flags AND write data: a 0 bit clears, a 1 bit keeps.
- R8: If an enabled edge and a clearing write reach the same flag bit in the same cycle, the bit ends up set.
- R9: Reading any offset, including offset 0 during an edge, has no effect on the flags or on `irq`.
- R10: `irq` equals, one cycle later, the global enable (offset 4, bit 0) ANDed with the OR of all flag bits.
- R11: Offsets 1, 2 and 4 read back what was last written (offset 4 in bit 0, upper bits 0). Unmapped offsets read 0.
- R12: Reset loads the synchronizer history with the current pin values, so a port held steady through reset sets no flag afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Asynchronous port pins |
| regAddr | input | 3 | Register offset |
| regWe | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for `regAddr` |
| irq | output | 1 | Registered interrupt request |

## Verification
Assertions check on every cycle that flags never drop without a clear strobe and that only bits with an enabled detected edge can newly rise. They also check that a clear without a competing edge yields exactly the masked value, and that `irq` tracks the previous cycle's gated OR. The bench scenarios cover the rest: synchronizer latency as seen at the port, the set-over-clear race, the absence of spurious flags after reset with non-zero pins, reads during edges, and readback of the configuration registers. A seeded random run of pin activity and register traffic is compared each cycle against a bench model.

// File: rtl/pei_pkg.sv
package pei_pkg;
  // register offsets; the order is the block's software contract
  localparam int unsigned OFS_PORT = 0;
  localparam int unsigned OFS_RISE = 1;
  localparam int unsigned OFS_FALL = 2;
  localparam int unsigned OFS_FLAG = 3;
  localparam int unsigned OFS_GIE  = 4;

  typedef struct packed {
    logic wrRise;
    logic wrFall;
    logic wrFlag;
    logic wrGie;
  } peiStrobe_t;
endpackage

// File: rtl/pei_ctrl.sv
module pei_ctrl import pei_pkg::*; #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PORT_W-1:0] portVal,
  input  logic [PORT_W-1:0] riseEn,
  input  logic [PORT_W-1:0] fallEn,
  input  logic [PORT_W-1:0] flags,
  input  logic              gie,
  output peiStrobe_t        strb,
  output logic [PORT_W-1:0] rdata
);
  always_comb begin
    strb        = '0;
    strb.wrRise = regWe && (regAddr == ADDR_W'(OFS_RISE));
    strb.wrFall = regWe && (regAddr == ADDR_W'(OFS_FALL));
    strb.wrFlag = regWe && (regAddr == ADDR_W'(OFS_FLAG));
    strb.wrGie  = regWe && (regAddr == ADDR_W'(OFS_GIE));
  end

  // side-effect-free read mux
  always_comb begin
    case (regAddr)
      ADDR_W'(OFS_PORT): rdata = portVal;
      ADDR_W'(OFS_RISE): rdata = riseEn;
      ADDR_W'(OFS_FALL): rdata = fallEn;
      ADDR_W'(OFS_FLAG): rdata = flags;
      ADDR_W'(OFS_GIE):  rdata = PORT_W'(gie);
      default:           rdata = '0;
    endcase
  end
endmodule

// File: rtl/pei_datapath.sv
module pei_datapath import pei_pkg::*; #(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinIn,
  input  peiStrobe_t        strb,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] portVal,
  output logic [PORT_W-1:0] riseEn,
  output logic [PORT_W-1:0] fallEn,
  output logic [PORT_W-1:0] flags,
  output logic              gie,
  output logic              irq
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic [PORT_W-1:0] prevQ;
  logic [PORT_W-1:0] riseSeen, fallSeen, setMask;

  // synchronizer chain; reset seeds every stage with the live pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= pinIn;
      prevQ <= pinIn;
    end else begin
      syncQ[0] <= pinIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign portVal  = syncQ[LAST];
  assign riseSeen = syncQ[LAST] & ~prevQ;
  assign fallSeen = ~syncQ[LAST] & prevQ;
  assign setMask  = (riseSeen & riseEn) | (fallSeen & fallEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseEn <= '0;
      fallEn <= '0;
      gie    <= 1'b0;
    end else begin
      if (strb.wrRise) riseEn <= wdata;
      if (strb.wrFall) fallEn <= wdata;
      if (strb.wrGie)  gie    <= wdata[0];
    end
  end

  // per-pin sticky flags: set has priority over the masked clear
  genvar g;
  generate
    for (g = 0; g < PORT_W; g++) begin : gFlag
      always_ff @(posedge clk) begin
        if (!rstN)           flags[g] <= 1'b0;
        else if (setMask[g]) flags[g] <= 1'b1;
        else if (strb.wrFlag) flags[g] <= flags[g] & wdata[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= gie & (|flags);
  end

  // R6: flags only drop on a clear strobe
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFlag |=> ((flags & $past(flags)) == $past(flags)));

  // R5: a newly set bit needs an enabled edge in the cycle before
  p_set_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & ~$past(flags) &
               ~$past((riseEn & syncQ[LAST] & ~prevQ) | (fallEn & ~syncQ[LAST] & prevQ))) == '0));

  // R7: clear with no competing edge gives the masked value
  p_clear_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrFlag && (syncQ[LAST] == prevQ)) |=> (flags == ($past(flags) & $past(wdata))));

  // R10: irq follows the gated OR one cycle later
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(gie && (flags != '0))));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq import pei_pkg::*; #(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [PORT_W-1:0] regWdata,
  output logic [PORT_W-1:0] regRdata,
  output logic              irq
);
  peiStrobe_t        strb;
  logic [PORT_W-1:0] portVal, riseEn, fallEn, flags;
  logic              gie;

  pei_ctrl #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .portVal(portVal), .riseEn(riseEn),
    .fallEn(fallEn), .flags(flags), .gie(gie), .strb(strb), .rdata(regRdata)
  );

  pei_datapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strb(strb), .wdata(regWdata),
    .portVal(portVal), .riseEn(riseEn), .fallEn(fallEn), .flags(flags),
    .gie(gie), .irq(irq)
  );
endmodule

// File: tb/sim_pin_edge_irq.sv
`timescale 1ns/1ps
module sim_pin_edge_irq;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pinIn, regWdata, regRdata;
  logic [2:0] regAddr;
  logic       regWe, irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_edge_irq u0 (.clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .irq(irq));

  // bench model built from the requirements
  logic [7:0] mS1, mS2, mPrev, mRise, mFall, mFlags;
  logic       mGie, mIrq;
  always @(posedge clk) begin
    if (!rstN) begin
      mS1 <= pinIn; mS2 <= pinIn; mPrev <= pinIn;
      mRise <= 0; mFall <= 0; mFlags <= 0; mGie <= 0; mIrq <= 0;
    end else begin
      mS1 <= pinIn; mS2 <= mS1; mPrev <= mS2;
      if (regWe && regAddr == 1) mRise <= regWdata;
      if (regWe && regAddr == 2) mFall <= regWdata;
      if (regWe && regAddr == 4) mGie <= regWdata[0];
      mFlags <= ((regWe && regAddr == 3) ? (mFlags & regWdata) : mFlags)
              | (mRise & mS2 & ~mPrev) | (mFall & ~mS2 & mPrev);
      mIrq <= mGie & (|mFlags);
    end
  end

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mS2;
      3'd1: return mRise;
      3'd2: return mFall;
      3'd3: return mFlags;
      3'd4: return {7'd0, mGie};
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWe = 1; regAddr = a; regWdata = d; tick(); regWe = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'd4711);
    rstN = 0; pinIn = 8'hA5; regAddr = 0; regWe = 0; regWdata = 0;
    tick(); tick();
    // R1 reset state
    rd(1, v); check("R1 rise", v, 8'h00);
    rd(2, v); check("R1 fall", v, 8'h00);
    rd(3, v); check("R1 flags", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rstN = 1;
    wr(1, 8'hFF); wr(2, 8'hFF); wr(4, 8'h01);
    repeat (4) tick();
    // R12 steady non-zero pins through reset: no flags
    rd(3, v); check("R12 no spurious flag", v, 8'h00);
    rd(0, v); check("R2 port value", v, 8'hA5);
    // R11 readback, unmapped, write to offset 0 ignored
    rd(1, v); check("R11 rise readback", v, 8'hFF);
    rd(4, v); check("R11 gie readback", v, 8'h01);
    rd(6, v); check("R11 unmapped", v, 8'h00);
    wr(0, 8'h3C); rd(0, v); check("R2 port write ignored", v, 8'hA5);
    // R2 latency, R9 reads during the edge, R3 rise
    wr(2, 8'h00); wr(1, 8'h02);
    regAddr = 0; pinIn = 8'hA7;            // bit1 rises, before edge k
    tick(); check("R2 one edge: old", regRdata, 8'hA5);
    tick(); check("R2 two edges: new", regRdata, 8'hA7);
    tick(); rd(3, v); check("R3 rise flag", v, 8'h02);
    check("R10 irq not yet", {7'd0, irq}, 8'h00);
    tick(); check("R10 irq one cycle later", {7'd0, irq}, 8'h01);
    rd(0, v); rd(0, v); tick();
    rd(3, v); check("R9 read keeps flag", v, 8'h02);
    check("R9 read keeps irq", {7'd0, irq}, 8'h01);
    // R5 disabled directions: bit0 falls (fall disabled), bit3 rises (rise disabled)
    pinIn = 8'hAE; repeat (4) tick();
    rd(3, v); check("R5 disabled edge", v, 8'h02);
    // R6 sticky through pin return
    pinIn = 8'hA5; repeat (4) tick();
    rd(3, v); check("R6 sticky", v, 8'h02);
    // R7 clear
    wr(3, 8'hFD); rd(3, v); check("R7 clear", v, 8'h00);
    tick(); check("R10 irq drops", {7'd0, irq}, 8'h00);
    // R4 fall
    wr(2, 8'h20); pinIn = 8'h85; repeat (3) tick();
    rd(3, v); check("R4 fall flag", v, 8'h20);
    // R8 set wins over clear in same cycle
    wr(3, 8'h00); wr(1, 8'h40);
    pinIn = 8'hC5; tick(); tick();
    regWe = 1; regAddr = 3; regWdata = 8'h00; tick(); regWe = 0;
    rd(3, v); check("R8 set over clear", v, 8'h40);
    wr(3, 8'h00); wr(4, 8'h00);
    rd(3, v); check("R7 full clear", v, 8'h00);
    // random run against the model
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) == 0) pinIn = pinIn ^ 8'($urandom_range(0, 255));
      regWe = ($urandom_range(0, 3) == 0);
      regAddr = 3'($urandom_range(0, 5));
      regWdata = 8'($urandom_range(0, 255));
      if (c == 1500) rstN = 0;
      if (c == 1503) rstN = 1;
      #1;
      check("R3/R4/R7/R11 random read", regRdata, expRead(regAddr));
      check("R10 random irq", {7'd0, irq}, {7'd0, mIrq});
      tick();
    end
    regWe = 0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule